// File: doc/BRIEF.md
# I2C SCL Clock Period Generator

This block produces the clock line of an I2C master. It pulls the line low for a programmed number of cycles, lets it go, and then waits a programmed number of cycles while the line is high before it pulls the line low again. Two pairs of counts are held inside the block, one pair for standard-mode speed and one pair for fast-mode speed. A speed-select input picks which pair is in use. Start and stop conditions and data shifting belong to neighbouring logic. That logic uses the phase strobes that this block emits.

The lengths of the phases are not the raw counts. The low phase starts counting in the same cycle that the line is first pulled, and it lasts one cycle more than its count. The high phase adds eight fixed cycles to its count, which model the synchronizer, the glitch filter and the fixed control overhead. High-phase counting advances only in cycles in which the sampled line is high, so a target that holds the clock low (clock stretching) lengthens the phase. A start-hold strobe fires once the high phase has counted its count plus three high cycles. This marks the hold point that follows a start condition. The counts can be written only while the generator is disabled. Counts below a floor are raised to that floor.

Top module: `scl_period_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `scl_drive_low`, `low_start`, `high_start` and `hold_tick` are all 0. All four count registers reset to 0.
- R2: A write with `cnt_wr`=1 and `enable`=0 stores `cnt_wdata` into the register that `cnt_sel` selects: 0 = standard high count, 1 = standard low count, 2 = fast high count, 3 = fast low count.
- R3: Once enabled, the block pulls the line low in the cycle after the first enabled clock edge. Each low phase keeps `scl_drive_low`=1 for exactly L+1 cycles, where L is the effective low count.
- R4: With no stretching, each released phase keeps `scl_drive_low`=0 for exactly H+8 cycles, where H is the effective high count. The next low phase follows immediately.
- R5: During a released phase, a clock edge at which `scl_in` is 0 does not advance the high count. The released phase therefore lengthens by one cycle for each such edge.
- R6: `hold_tick` is high for one cycle, in the cycle after the edge at which the released phase has counted its (H+3)-th high sample. With no stretching, this is released cycle index H+3, counting from 0.
- R7: `low_start` is high exactly in the first cycle of each low phase. `high_start` is high exactly in the first cycle of each released phase.
- R8: A write made while `enable`=1 is ignored. The phase lengths that follow, both during that run and after a re-enable, use the old values.
- R9: At the first clock edge with `enable`=0, the line is released and all strobes drop. The phase counter clears, so the next enable starts with a full L+1 low phase.
- R10: The effective low count is max(low register, 8). The effective high count is max(high register, 6).
- R11: `fast_sel`=1 uses the fast pair (registers 2 and 3). `fast_sel`=0 uses the standard pair (registers 0 and 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator. While it is 1, count writes are locked out |
| fast_sel | input | 1 | 1 selects the fast-mode count pair, 0 selects the standard pair |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_sel | input | 2 | Selects the count register to write (encoding in R2) |
| cnt_wdata | input | CW (16) | Count value to write |
| scl_in | input | 1 | Sampled level of the clock line |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| low_start | output | 1 | One-cycle strobe in the first cycle of a low phase |
| high_start | output | 1 | One-cycle strobe in the first cycle of a released phase |
| hold_tick | output | 1 | One-cycle strobe at the start-hold point of a released phase |

## Verification
The hardest case to reach is clock stretching that sits exactly on the boundary of the released phase. The bench drives a stretch flag that holds the sampled line low. It raises the flag at the falling edge inside the first released cycle and clears it after a chosen count, so a known number of high samples are lost. The expected phase length and the expected position of the hold strobe both shift by that count. A second hard case is disabling in the middle of a phase. The stimulus drops `enable` a few cycles into a low phase and again right at the start of a released phase. It then checks that the next run begins with a complete low phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Count register select codes (write port decode)
  typedef enum logic [1:0] {
    CSEL_STD_HIGH  = 2'd0,
    CSEL_STD_LOW   = 2'd1,
    CSEL_FAST_HIGH = 2'd2,
    CSEL_FAST_LOW  = 2'd3
  } cnt_sel_e;

  localparam int unsigned NUM_CNT_REGS = 4;
  localparam int unsigned LOW_FLOOR    = 8;  // minimum effective low count
  localparam int unsigned HIGH_FLOOR   = 6;  // minimum effective high count
  localparam int unsigned HIGH_FIXED   = 8;  // sync + filter + control cycles
  localparam int unsigned HOLD_FIXED   = 3;  // start-hold offset past the high count

endpackage

// File: rtl/scl_cnt_bank.sv
module scl_cnt_bank
  import scl_gen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             lock,
  input  logic                             wr_en,
  input  logic [1:0]                       wr_sel,
  input  logic [CW-1:0]                    wr_data,
  output logic [NUM_CNT_REGS-1:0][CW-1:0]  bank
);

  for (genvar gi = 0; gi < NUM_CNT_REGS; gi++) begin : g_reg
    logic [CW-1:0] q;

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && !lock && (wr_sel == 2'(gi))) begin
        q <= wr_data;
      end
    end

    assign bank[gi] = q;
  end

endmodule

// File: rtl/scl_cnt_select.sv
module scl_cnt_select
  import scl_gen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                             fast_sel,
  input  logic [NUM_CNT_REGS-1:0][CW-1:0]  bank,
  output logic [CW-1:0]                    low_eff,
  output logic [CW-1:0]                    high_eff
);

  localparam logic [CW-1:0] LOW_MIN  = CW'(LOW_FLOOR);
  localparam logic [CW-1:0] HIGH_MIN = CW'(HIGH_FLOOR);

  logic [CW-1:0] low_raw;
  logic [CW-1:0] high_raw;

  always_comb begin
    if (fast_sel) begin
      low_raw  = bank[CSEL_FAST_LOW];
      high_raw = bank[CSEL_FAST_HIGH];
    end else begin
      low_raw  = bank[CSEL_STD_LOW];
      high_raw = bank[CSEL_STD_HIGH];
    end
    low_eff  = (low_raw  < LOW_MIN)  ? LOW_MIN  : low_raw;
    high_eff = (high_raw < HIGH_MIN) ? HIGH_MIN : high_raw;
  end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_gen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          scl_in,
  input  logic [CW-1:0] low_eff,
  input  logic [CW-1:0] high_eff,
  output logic          drive_low,
  output logic          low_start,
  output logic          high_start,
  output logic          hold_tick
);

  // One extra bit so that high count plus fixed overhead cannot wrap
  localparam int PW = CW + 1;

  logic          running;
  logic [PW-1:0] cnt;
  logic [PW-1:0] low_end;
  logic [PW-1:0] high_end;
  logic [PW-1:0] hold_pt;

  assign low_end  = {1'b0, low_eff};
  assign high_end = {1'b0, high_eff} + PW'(HIGH_FIXED - 1);
  assign hold_pt  = {1'b0, high_eff} + PW'(HOLD_FIXED - 1);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      running    <= 1'b0;
      drive_low  <= 1'b0;
      cnt        <= '0;
      low_start  <= 1'b0;
      high_start <= 1'b0;
      hold_tick  <= 1'b0;
    end else begin
      low_start  <= 1'b0;
      high_start <= 1'b0;
      hold_tick  <= 1'b0;
      if (!running) begin
        // first enabled edge: pull the line and start counting at once
        running   <= 1'b1;
        drive_low <= 1'b1;
        cnt       <= '0;
        low_start <= 1'b1;
      end else if (drive_low) begin
        if (cnt == low_end) begin
          drive_low  <= 1'b0;
          cnt        <= '0;
          high_start <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (scl_in) begin
        // released phase advances only on high samples
        hold_tick <= (cnt == hold_pt);
        if (cnt == high_end) begin
          drive_low <= 1'b1;
          cnt       <= '0;
          low_start <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          fast_sel,
  input  logic          cnt_wr,
  input  logic [1:0]    cnt_sel,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          scl_in,
  output logic          scl_drive_low,
  output logic          low_start,
  output logic          high_start,
  output logic          hold_tick
);

  logic [NUM_CNT_REGS-1:0][CW-1:0] bank;
  logic [CW-1:0]                   low_eff;
  logic [CW-1:0]                   high_eff;

  scl_cnt_bank #(.CW(CW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .lock    (enable),
    .wr_en   (cnt_wr),
    .wr_sel  (cnt_sel),
    .wr_data (cnt_wdata),
    .bank    (bank)
  );

  scl_cnt_select #(.CW(CW)) u_sel (
    .fast_sel (fast_sel),
    .bank     (bank),
    .low_eff  (low_eff),
    .high_eff (high_eff)
  );

  scl_phase_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .scl_in     (scl_in),
    .low_eff    (low_eff),
    .high_eff   (high_eff),
    .drive_low  (scl_drive_low),
    .low_start  (low_start),
    .high_start (high_start),
    .hold_tick  (hold_tick)
  );

endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic scl_in,
  input logic scl_drive_low,
  input logic low_start,
  input logic high_start,
  input logic hold_tick
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!scl_drive_low && !low_start && !high_start && !hold_tick));

  a_r9_disable_release: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!scl_drive_low && !low_start && !high_start && !hold_tick));

  a_r7_low_start_edge: assert property (@(posedge clk) disable iff (rst)
    low_start |-> (scl_drive_low && !$past(scl_drive_low)));

  a_r7_high_start_edge: assert property (@(posedge clk) disable iff (rst)
    high_start |-> (!scl_drive_low && $past(scl_drive_low)));

  a_r6_hold_in_release: assert property (@(posedge clk) disable iff (rst)
    hold_tick |-> !scl_drive_low);

  a_r5_stretch_holds: assert property (@(posedge clk) disable iff (rst)
    (high_start && enable && !scl_in) |=> !scl_drive_low);

  a_r3_low_persists: assert property (@(posedge clk) disable iff (rst)
    (low_start && enable) |=> scl_drive_low);

endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .enable        (enable),
  .scl_in        (scl_in),
  .scl_drive_low (scl_drive_low),
  .low_start     (low_start),
  .high_start    (high_start),
  .hold_tick     (hold_tick)
);

// File: tb/tb_scl_period_gen.sv
`timescale 1ns/1ps
module tb_scl_period_gen;
  import scl_gen_pkg::*;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          fast_sel = 1'b0;
  logic          cnt_wr = 1'b0;
  logic [1:0]    cnt_sel = 2'd0;
  logic [CW-1:0] cnt_wdata = '0;
  logic          stretch = 1'b0;
  logic          scl_in;
  logic          scl_drive_low, low_start, high_start, hold_tick;

  assign scl_in = !scl_drive_low && !stretch;

  always #2 clk = ~clk;

  scl_period_gen #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .enable(enable), .fast_sel(fast_sel),
    .cnt_wr(cnt_wr), .cnt_sel(cnt_sel), .cnt_wdata(cnt_wdata),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .low_start(low_start),
    .high_start(high_start), .hold_tick(hold_tick)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_reg [4] = '{0, 0, 0, 0};
  bit m_run = 0, e_low = 0, e_ls = 0, e_hs = 0, e_ht = 0;
  int m_left = 0, m_held = 0;

  always @(posedge clk) begin
    int l_eff, h_eff;
    l_eff = fast_sel ? m_reg[3] : m_reg[1];
    h_eff = fast_sel ? m_reg[2] : m_reg[0];
    if (l_eff < 8) l_eff = 8;
    if (h_eff < 6) h_eff = 6;
    e_ls = 0; e_hs = 0; e_ht = 0;
    if (rst || !enable) begin
      m_run = 0; e_low = 0;
    end else if (!m_run) begin
      m_run = 1; e_low = 1; e_ls = 1; m_left = l_eff;
    end else if (e_low) begin
      if (m_left == 0) begin
        e_low = 0; e_hs = 1; m_left = h_eff + 7; m_held = 0;
      end else m_left--;
    end else if (scl_in) begin
      m_held++;
      if (m_held == h_eff + 3) e_ht = 1;
      if (m_left == 0) begin
        e_low = 1; e_ls = 1; m_left = l_eff;
      end else m_left--;
    end
    if (rst) m_reg = '{0, 0, 0, 0};
    else if (cnt_wr && !enable) m_reg[cnt_sel] = int'(cnt_wdata);
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "scl_drive_low", int'(scl_drive_low), int'(e_low));
      chk("R7", "low_start", int'(low_start), int'(e_ls));
      chk("R7", "high_start", int'(high_start), int'(e_hs));
      chk("R6", "hold_tick", int'(hold_tick), int'(e_ht));
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic write_cnt(input logic [1:0] sel, input int val);
    cnt_wr = 1'b1; cnt_sel = sel; cnt_wdata = CW'(val);
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  // Measures one full period starting at the next low_start (checked at falling edges)
  task automatic run_period(input int exp_low, input int exp_high, input int exp_hold,
                            input int stretch_n, input string tag);
    int lowlen = 0, highlen = 0, holdidx = -1;
    while (!low_start) @(negedge clk);
    while (scl_drive_low) begin lowlen++; @(negedge clk); end
    stretch = (stretch_n > 0);
    while (!scl_drive_low) begin
      if (hold_tick) holdidx = highlen;
      highlen++;
      if (highlen == stretch_n) stretch = 1'b0;
      @(negedge clk);
    end
    chk("R3", {tag, " low length"}, lowlen, exp_low);
    chk(stretch_n > 0 ? "R5" : "R4", {tag, " released length"}, highlen, exp_high);
    chk("R6", {tag, " hold index"}, holdidx, exp_hold);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "drive after reset", int'(scl_drive_low), 0);
    chk("R1", "strobes after reset", int'(low_start | high_start | hold_tick), 0);

    // R2: program both pairs via the select encoding
    cur_req = "R2";
    write_cnt(CSEL_STD_HIGH, 10);
    write_cnt(CSEL_STD_LOW, 12);
    write_cnt(CSEL_FAST_HIGH, 7);
    write_cnt(CSEL_FAST_LOW, 9);

    // R3/R4/R6: standard pair, two back-to-back periods
    cur_req = "R3";
    enable = 1'b1;
    run_period(13, 18, 13, 0, "R2 std pair");
    run_period(13, 18, 13, 0, "R4 repeat");

    // R8: writes while enabled are ignored
    cur_req = "R8";
    write_cnt(CSEL_STD_LOW, 20);
    write_cnt(CSEL_STD_HIGH, 30);
    run_period(13, 18, 13, 0, "R8 locked write");
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    run_period(13, 18, 13, 0, "R8 after re-enable");

    // R11: fast pair
    cur_req = "R11";
    enable = 1'b0;
    fast_sel = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    run_period(10, 15, 10, 0, "R11 fast pair");

    // R5: stretching shifts release length and hold point
    cur_req = "R5";
    run_period(10, 20, 15, 6, "R5 stretch");
    run_period(10, 15, 10, 0, "R5 after stretch");

    // R10: floor on small counts, and exact floor values
    cur_req = "R10";
    enable = 1'b0;
    @(negedge clk);
    write_cnt(CSEL_FAST_LOW, 8);
    write_cnt(CSEL_FAST_HIGH, 6);
    enable = 1'b1;
    run_period(9, 14, 9, 0, "R10 exact floor");
    enable = 1'b0;
    fast_sel = 1'b0;
    @(negedge clk);
    write_cnt(CSEL_STD_LOW, 3);
    write_cnt(CSEL_STD_HIGH, 2);
    enable = 1'b1;
    run_period(9, 14, 9, 0, "R10 below floor");

    // R9: disable mid low phase, then mid released phase
    cur_req = "R9";
    enable = 1'b0;
    @(negedge clk);
    write_cnt(CSEL_STD_LOW, 11);
    write_cnt(CSEL_STD_HIGH, 9);
    enable = 1'b1;
    while (!low_start) @(negedge clk);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R9", "drive after disable in low", int'(scl_drive_low), 0);
    @(negedge clk);
    enable = 1'b1;
    run_period(12, 17, 12, 0, "R9 restart after low disable");
    while (!high_start) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R9", "drive after disable in release", int'(scl_drive_low), 0);
    chk("R9", "hold after disable in release", int'(hold_tick), 0);
    enable = 1'b1;
    run_period(12, 17, 12, 0, "R9 restart after release disable");

    enable = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule